// File: doc/BRIEF.md
# Selectable-Source Clock Divider Cell

This cell makes one derived clock from several source clocks. A primary source is always present. A bank of further sources can be reached through an indexed selector, and a selection bit decides whether the primary or the indexed source feeds the divider. The chosen source then passes through one of three paths: a programmable divider with a fixed set of ratios, a bypass with ratio 1, or a fixed divide-by-3 path that takes priority over both. A gate at the output can hold the derived clock low.

All logic runs on a single system clock. Each source is presented as a one-cycle tick per source period, and the derived clock comes out as a registered level plus a one-cycle rising-edge strobe. The cell takes a new source, ratio or enable setting only at the end of the current output period, so the output never shows a runt pulse. Parameters remove the source selector and the gate for instances that do not need them. When removed, the cell always uses the primary source and the output is always enabled.

Top module: `clkdiv_cell`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_clk` and `out_rise` are 0. Reset leaves the cell on the primary source, with ratio 1 and the output disabled.
- R2: When `src_use_mux` is 0, only `prim_tick` drives the divider, and `src_idx` and `pll_tick` have no effect on the output.
- R3: When `src_use_mux` is 1, `pll_tick[src_idx]` drives the divider. Index value k corresponds to logical parent k+1.
- R4: When `div_use` is 1 and `div3_sel` is 0, `div_code` values 0 to 7 give ratios 1, 2, 4, 6, 8, 12, 1 and 1, counted in ticks of the selected source.
- R5: When `div_use` is 0 and `div3_sel` is 0, the ratio is 1 whatever the value of `div_code`.
- R6: When `div3_sel` is 1, the ratio is 3 with one source tick high and two low, whatever the values of `div_use` and `div_code`.
- R7: Every even ratio gives `out_clk` high for exactly half of the period. Ratio 1 gives a constantly high level.
- R8: `gate_en` passes through a two-stage synchroniser and takes effect only at a period boundary. While it is 0, `out_clk` stays low and `out_rise` never fires.
- R9: A change of source, ratio or enable made during an output period leaves that period at its old length. The new setting governs the next period. The output never changes in a cycle that follows no source tick.
- R10: `out_rise` pulses for one cycle, one cycle after the source tick that starts each enabled period, and `out_clk` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| prim_tick | input | 1 | Primary source tick, one cycle per source period |
| pll_tick | input | NUM_PLL | Indexed source ticks |
| src_use_mux | input | 1 | 0: primary source, 1: indexed source |
| src_idx | input | 3 | Index into `pll_tick` |
| div_use | input | 1 | 0: divider bypassed, 1: ratio from `div_code` |
| div_code | input | 3 | Ratio code |
| div3_sel | input | 1 | Selects the dominant divide-by-3 path |
| gate_en | input | 1 | Output enable, asynchronous to periods |
| out_clk | output | 1 | Divided, gated clock level |
| out_rise | output | 1 | One-cycle strobe at each rising edge of `out_clk` |

## Verification
A control write and a period boundary can fall in the same part of a period: a new ratio can arrive while an output period is still running. The bench provokes this by waiting for a rising-edge strobe at ratio 12 and writing ratio 2 three cycles later. It then measures the gap to the next strobe, which must still be the full old period, and the gap after that, which must follow the new ratio. Ratios, source choices and duty cycles are measured by counting strobes and high cycles over a window that spans a whole number of output periods, so the expected counts are exact.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int IDX_W  = 3;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] hi;
  } div_cfg_t;

  function automatic logic [CNT_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    code_ratio = 4'd2;
      3'd2:    code_ratio = 4'd4;
      3'd3:    code_ratio = 4'd6;
      3'd4:    code_ratio = 4'd8;
      3'd5:    code_ratio = 4'd12;
      default: code_ratio = 4'd1;
    endcase
  endfunction

  function automatic div_cfg_t decode_cfg(input logic use_div,
                                          input logic [CODE_W-1:0] code,
                                          input logic d3);
    div_cfg_t c;
    if (d3) begin
      c.ratio = 4'd3;
      c.hi    = 4'd1;
    end else if (!use_div) begin
      c.ratio = 4'd1;
      c.hi    = 4'd1;
    end else begin
      c.ratio = code_ratio(code);
      c.hi    = (c.ratio > 4'd1) ? (c.ratio >> 1) : 4'd1;
    end
    return c;
  endfunction
endpackage

// File: rtl/clkdiv_src_select.sv
module clkdiv_src_select #(
  parameter int NUM_PLL = 8,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic                             prim_tick,
  input  logic [NUM_PLL-1:0]               pll_tick,
  input  logic                             use_mux,
  input  logic [clkdiv_pkg::IDX_W-1:0]     idx,
  output logic                             sel_tick
);
  localparam int SLOTS = 1 << clkdiv_pkg::IDX_W;

  generate
    if (HAS_MUX) begin : g_mux
      logic [SLOTS-1:0] padded;
      always_comb begin
        padded = '0;
        padded[NUM_PLL-1:0] = pll_tick;
      end
      assign sel_tick = use_mux ? padded[idx] : prim_tick;
    end else begin : g_nomux
      logic unused_mux;
      assign unused_mux = ^{pll_tick, use_mux, idx};
      assign sel_tick   = prim_tick;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync #(
  parameter int STAGES   = 2,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_out
);
  generate
    if (HAS_GATE) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], en_in};
      end
      assign en_out = chain[STAGES-1];
    end else begin : g_tied
      logic unused_en;
      assign unused_en = ^{clk, rst, en_in};
      assign en_out    = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_tick,
  input  div_cfg_t         req_cfg,
  input  logic             req_use_mux,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             en_s,
  output logic             cur_use_mux,
  output logic [IDX_W-1:0] cur_idx,
  output logic             out_clk,
  output logic             out_rise
);
  logic [CNT_W-1:0] cnt;
  div_cfg_t         cur_cfg;
  logic             cur_en;
  logic             boundary;

  assign boundary = sel_tick && (cnt == cur_cfg.ratio - 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      cur_cfg     <= '{ratio: 4'd1, hi: 4'd1};
      cur_en      <= 1'b0;
      cur_use_mux <= 1'b0;
      cur_idx     <= '0;
      out_clk     <= 1'b0;
      out_rise    <= 1'b0;
    end else begin
      out_rise <= 1'b0;
      if (boundary) begin
        cnt         <= '0;
        cur_cfg     <= req_cfg;
        cur_use_mux <= req_use_mux;
        cur_idx     <= req_idx;
        cur_en      <= en_s;
        out_clk     <= en_s;
        out_rise    <= en_s;
      end else if (sel_tick) begin
        cnt     <= cnt + 4'd1;
        out_clk <= cur_en && ((cnt + 4'd1) < cur_cfg.hi);
      end
    end
  end
endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
  import clkdiv_pkg::*;
#(
  parameter int NUM_PLL  = 8,
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prim_tick,
  input  logic [NUM_PLL-1:0] pll_tick,
  input  logic               src_use_mux,
  input  logic [IDX_W-1:0]   src_idx,
  input  logic               div_use,
  input  logic [CODE_W-1:0]  div_code,
  input  logic               div3_sel,
  input  logic               gate_en,
  output logic               out_clk,
  output logic               out_rise
);
  logic             sel_tick;
  logic             en_s;
  logic             cur_use_mux;
  logic [IDX_W-1:0] cur_idx;
  div_cfg_t         req_cfg;

  assign req_cfg = decode_cfg(div_use, div_code, div3_sel);

  clkdiv_src_select #(.NUM_PLL(NUM_PLL), .HAS_MUX(HAS_MUX)) u_sel (
    .prim_tick (prim_tick),
    .pll_tick  (pll_tick),
    .use_mux   (cur_use_mux),
    .idx       (cur_idx),
    .sel_tick  (sel_tick)
  );

  clkdiv_en_sync #(.STAGES(SYNC_STG), .HAS_GATE(HAS_GATE)) u_en (
    .clk    (clk),
    .rst    (rst),
    .en_in  (gate_en),
    .en_out (en_s)
  );

  clkdiv_period_ctr u_ctr (
    .clk         (clk),
    .rst         (rst),
    .sel_tick    (sel_tick),
    .req_cfg     (req_cfg),
    .req_use_mux (src_use_mux),
    .req_idx     (src_idx),
    .en_s        (en_s),
    .cur_use_mux (cur_use_mux),
    .cur_idx     (cur_idx),
    .out_clk     (out_clk),
    .out_rise    (out_rise)
  );
endmodule

// File: rtl/clkdiv_cell_chk.sv
module clkdiv_cell_chk #(
  parameter int NUM_PLL = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               prim_tick,
  input logic [NUM_PLL-1:0] pll_tick,
  input logic               out_clk,
  input logic               out_rise
);
  logic any_tick;
  assign any_tick = prim_tick || (|pll_tick);

  // R1: outputs quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_clk && !out_rise));

  // R10: strobe marks a high level
  a_r10_rise_high: assert property (@(posedge clk) disable iff (rst)
    out_rise |-> out_clk);

  // R10: strobe only follows a source tick
  a_r10_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
    out_rise |-> $past(any_tick));

  // R9: without a tick the output holds
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(any_tick) && !$past(rst)) |-> ($stable(out_clk) && !out_rise));
endmodule

bind clkdiv_cell clkdiv_cell_chk #(.NUM_PLL(NUM_PLL)) u_chk (.*);

// File: tb/tb_clkdiv_cell.sv
`timescale 1ns/1ps
module tb_clkdiv_cell;
  localparam int NP  = 8;
  localparam int WIN = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prim_tick = 1'b0;
  logic [NP-1:0] pll_tick = '0;
  logic src_use_mux = 1'b0;
  logic [2:0] src_idx = 3'd0;
  logic div_use = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic div3_sel = 1'b0;
  logic gate_en = 1'b0;
  logic out_clk, out_rise;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_cell #(.NUM_PLL(NP)) dut (
    .clk(clk), .rst(rst), .prim_tick(prim_tick), .pll_tick(pll_tick),
    .src_use_mux(src_use_mux), .src_idx(src_idx), .div_use(div_use),
    .div_code(div_code), .div3_sel(div3_sel), .gate_en(gate_en),
    .out_clk(out_clk), .out_rise(out_rise)
  );

  // primary period 2 cycles, indexed source k period 3+k cycles
  initial begin
    int ph [NP+1];
    for (int i = 0; i <= NP; i++) ph[i] = 0;
    forever begin
      @(negedge clk);
      prim_tick = (ph[0] == 0);
      ph[0] = (ph[0] + 1) % 2;
      for (int k = 0; k < NP; k++) begin
        pll_tick[k] = (ph[k+1] == 0);
        ph[k+1] = (ph[k+1] + 1) % (3 + k);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int per, output int rises, output int highs, output int bad);
    rises = 0; highs = 0; bad = 0;
    repeat (WIN * per) begin
      @(negedge clk);
      if (out_rise) rises++;
      if (out_clk) highs++;
      if (out_rise && !out_clk) bad++;
    end
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic run_ratio(input string req, input int per, input int ratio, input int hi);
    int r, h, b;
    settle();
    measure(per, r, h, b);
    check(r == WIN / ratio, {req, " rise count"}, r, WIN / ratio);
    check(h == (WIN / ratio) * hi * per, {req, " high cycles"}, h, (WIN / ratio) * hi * per);
    check(b == 0, "R10 rise with low level", b, 0);
  endtask

  task automatic t_reset();
    check(out_clk == 1'b0 && out_rise == 1'b0, "R1 in reset", out_clk, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_clk == 1'b0 && out_rise == 1'b0, "R1 after release", out_clk, 0);
    repeat (40) @(negedge clk);
    check(out_clk == 1'b0, "R1 disabled by default", out_clk, 0);
    gate_en = 1'b1;
  endtask

  task automatic t_primary();
    src_use_mux = 1'b0; div_use = 1'b0;
    src_idx = 3'd5;
    run_ratio("R2 primary idx5", 2, 1, 1);
    src_idx = 3'd2;
    run_ratio("R2 primary idx2", 2, 1, 1);
  endtask

  task automatic t_indexed();
    src_use_mux = 1'b1; div_use = 1'b0;
    for (int k = 0; k < NP; k++) begin
      src_idx = 3'(k);
      run_ratio($sformatf("R3 index %0d", k), 3 + k, 1, 1);
    end
    src_use_mux = 1'b0;
  endtask

  task automatic t_codes();
    int rat [8] = '{1, 2, 4, 6, 8, 12, 1, 1};
    div_use = 1'b1; div3_sel = 1'b0;
    for (int c = 0; c < 8; c++) begin
      div_code = 3'(c);
      run_ratio($sformatf("R4 R7 code %0d", c), 2, rat[c], (rat[c] > 1) ? rat[c] / 2 : 1);
    end
    src_use_mux = 1'b1; src_idx = 3'd1; div_code = 3'd3;
    run_ratio("R4 R7 code 3 on index 1", 4, 6, 3);
    src_use_mux = 1'b0;
  endtask

  task automatic t_bypass();
    div_use = 1'b0; div3_sel = 1'b0;
    div_code = 3'd5;
    run_ratio("R5 bypass code5", 2, 1, 1);
    div_code = 3'd2;
    run_ratio("R5 bypass code2", 2, 1, 1);
  endtask

  task automatic t_div3();
    div3_sel = 1'b1;
    div_use = 1'b1; div_code = 3'd5;
    run_ratio("R6 div3 over code5", 2, 3, 1);
    div_use = 1'b0;
    run_ratio("R6 div3 over bypass", 2, 3, 1);
    src_use_mux = 1'b1; src_idx = 3'd0;
    run_ratio("R6 div3 on index 0", 3, 3, 1);
    div3_sel = 1'b0; src_use_mux = 1'b0;
  endtask

  task automatic t_gate();
    int r, h, b;
    div_use = 1'b1; div_code = 3'd1;
    gate_en = 1'b0;
    settle();
    measure(2, r, h, b);
    check(r == 0, "R8 gated rises", r, 0);
    check(h == 0, "R8 gated high cycles", h, 0);
    gate_en = 1'b1;
    run_ratio("R8 re-enabled", 2, 2, 1);
  endtask

  task automatic t_boundary();
    int n;
    div_use = 1'b1; div_code = 3'd5;
    settle();
    do @(negedge clk); while (!out_rise);
    repeat (3) @(negedge clk);
    div_code = 3'd1;
    n = 3;
    do begin @(negedge clk); n++; end while (!out_rise);
    check(n == 24, "R9 old period kept", n, 24);
    n = 0;
    do begin @(negedge clk); n++; end while (!out_rise);
    check(n == 4, "R9 new period applied", n, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_primary();
    t_indexed();
    t_codes();
    t_bypass();
    t_div3();
    t_gate();
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule